// File: doc/BRIEF.md
# Delayed-Branch Three-Stage Load/Store Core

This block is a small 16-bit load/store processor with three pipeline steps. Fetch presents the program counter to a synchronous instruction memory. Execute decodes the returned word, reads the register file, runs the ALU and resolves control flow. Data access returns load data from a synchronous data memory and writes it back. In steady state one instruction enters execute on every clock cycle. ALU operations only work between registers. Memory is reached only by load and store, which use a base register plus a signed 6-bit offset.

Control transfers are delayed by one slot. The word after a jump or branch is always executed in full, and fetch continues at the target after it. There is no squash path. A load whose result is needed by the instruction right behind it costs exactly one held cycle. A halt instruction freezes fetch and raises `done`. A debug port reads any register, so a test environment can compare the final architectural state.

Top module: `dslot_core`

## Requirements
- R1: While `rst` is high the fetch address is 0, `done` is low and no data write is issued. After reset every register reads zero.
- R2: The instruction word is op[15:12], rd[11:9], rs[8:6], rt[5:3], imm[5:0] (signed). Opcodes 1..5 perform rd = rs+rt, rs-rt, rs&rt, rs|rt, rs^rt. Opcode 6 performs rd = rs+imm. Opcode 0 and the unused codes 11..14 change nothing.
- R3: Register 0 reads as zero, and writes to it are discarded.
- R4: A result written by one instruction is seen by the next instruction with no extra cycle.
- R5: Opcode 7 loads rd from data address rs+imm. Opcode 8 stores register rd to data address rs+imm.
- R6: When an instruction reads the destination of the load just ahead of it, it still gets the loaded value, and the whole run takes exactly one extra cycle per such pair.
- R7: Opcode 9 jumps to (its own address + 1 + imm). The next sequential instruction still executes, and the instructions between it and the target do not.
- R8: Opcode 10 branches like opcode 9 only when register rs equals zero. Its delay-slot instruction executes whether or not the branch is taken.
- R9: Opcode 15 raises `done`, which stays high. After that the fetch address no longer moves, no data write occurs, and instructions after the halt have no effect.
- R10: With no load-use pair and no redirect, the fetch address advances by one each cycle. A hazard-free program of N instructions ending in a halt raises `done` N+1 cycles after reset release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| imemAddr | output | PC_W | Instruction fetch address |
| imemRdata | input | 16 | Instruction word, one cycle after its address |
| dmemAddr | output | DADDR_W | Data memory address |
| dmemRe | output | 1 | Data read strobe |
| dmemWe | output | 1 | Data write strobe |
| dmemWdata | output | 16 | Store data |
| dmemRdata | input | 16 | Load data, one cycle after its address |
| dbgAddr | input | 3 | Debug register select |
| dbgData | output | 16 | Debug register value |
| done | output | 1 | Halt reached |

## Verification
The bench targets the delay slot after both a jump and a taken branch, a not-taken branch, and a backward branch whose delay slot changes the branch's own condition. A core that squashed the slot would lose those writes, and one that redirected late would run instructions that must be skipped. Load-use pairs are tested through an ALU source, a store's data register and an immediate base. A core without the hold would compute with stale values, and one that held too long would miss the exact cycle count. The bench also checks that the instruction behind a halt does not retire and that writes to register 0 vanish, which catches a missing kill or a missing write guard.

// File: rtl/dslot_pkg.sv
package dslot_pkg;
  localparam int INSTR_W  = 16;
  localparam int DATA_W   = 16;
  localparam int OP_W     = 4;
  localparam int NUM_REGS = 8;
  localparam int RA_W     = $clog2(NUM_REGS);
  localparam int IMM_W    = 6;

  localparam logic [OP_W-1:0] OPC_NOP  = 4'd0;
  localparam logic [OP_W-1:0] OPC_ADD  = 4'd1;
  localparam logic [OP_W-1:0] OPC_SUB  = 4'd2;
  localparam logic [OP_W-1:0] OPC_AND  = 4'd3;
  localparam logic [OP_W-1:0] OPC_OR   = 4'd4;
  localparam logic [OP_W-1:0] OPC_XOR  = 4'd5;
  localparam logic [OP_W-1:0] OPC_ADDI = 4'd6;
  localparam logic [OP_W-1:0] OPC_LD   = 4'd7;
  localparam logic [OP_W-1:0] OPC_ST   = 4'd8;
  localparam logic [OP_W-1:0] OPC_JMP  = 4'd9;
  localparam logic [OP_W-1:0] OPC_BEZ  = 4'd10;
  localparam logic [OP_W-1:0] OPC_HALT = 4'd15;

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0,
    ALU_SUB = 3'd1,
    ALU_AND = 3'd2,
    ALU_OR  = 3'd3,
    ALU_XOR = 3'd4
  } aluOpT;

  // Strobes from control to datapath; all already qualified by a firing slot.
  typedef struct packed {
    logic  regWe;
    aluOpT aluOp;
    logic  useImm;
    logic  memRd;
    logic  memWr;
    logic  jump;
    logic  branch;
    logic  halt;
    logic  stall;
  } ctrlT;
endpackage

// File: rtl/dslot_alu.sv
module dslot_alu
  import dslot_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  aluOpT        op,
  output logic [W-1:0] result
);
  always_comb begin
    unique case (op)
      ALU_ADD: result = opA + opB;
      ALU_SUB: result = opA - opB;
      ALU_AND: result = opA & opB;
      ALU_OR:  result = opA | opB;
      ALU_XOR: result = opA ^ opB;
      default: result = opA + opB;
    endcase
  end
endmodule

// File: rtl/dslot_regfile.sv
module dslot_regfile #(
  parameter int W      = 16,
  parameter int NREGS  = 8,
  parameter int NREAD  = 4,
  parameter int NWRITE = 2,
  localparam int AW    = $clog2(NREGS)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NREAD-1:0][AW-1:0]    rdAddr,
  output logic [NREAD-1:0][W-1:0]     rdData,
  input  logic [NWRITE-1:0]           wrEn,
  input  logic [NWRITE-1:0][AW-1:0]   wrAddr,
  input  logic [NWRITE-1:0][W-1:0]    wrData
);
  logic [W-1:0] regs [NREGS];

  // Higher-numbered write ports win on a collision (younger instruction).
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else begin
      for (int w = 0; w < NWRITE; w++) begin
        if (wrEn[w] && (wrAddr[w] != '0)) regs[wrAddr[w]] <= wrData[w];
      end
    end
  end

  for (genvar p = 0; p < NREAD; p++) begin : g_read
    assign rdData[p] = regs[rdAddr[p]];
  end
endmodule

// File: rtl/dslot_control.sv
module dslot_control
  import dslot_pkg::*;
(
  input  logic [OP_W-1:0] op,
  input  logic [RA_W-1:0] rd,
  input  logic [RA_W-1:0] rs,
  input  logic [RA_W-1:0] rt,
  input  logic            eValid,
  input  logic            loadPend,
  input  logic [RA_W-1:0] loadRd,
  output ctrlT            ctrl
);
  logic  wantWe, useImm, memRd, memWr, jmp, br, hlt;
  logic  readA, readB, readD;
  aluOpT aluSel;
  logic  hazard, fire;

  always_comb begin
    wantWe = 1'b0; useImm = 1'b0; memRd = 1'b0; memWr = 1'b0;
    jmp = 1'b0; br = 1'b0; hlt = 1'b0;
    readA = 1'b0; readB = 1'b0; readD = 1'b0;
    aluSel = ALU_ADD;
    case (op)
      OPC_ADD:  begin wantWe = 1'b1; readA = 1'b1; readB = 1'b1; aluSel = ALU_ADD; end
      OPC_SUB:  begin wantWe = 1'b1; readA = 1'b1; readB = 1'b1; aluSel = ALU_SUB; end
      OPC_AND:  begin wantWe = 1'b1; readA = 1'b1; readB = 1'b1; aluSel = ALU_AND; end
      OPC_OR:   begin wantWe = 1'b1; readA = 1'b1; readB = 1'b1; aluSel = ALU_OR;  end
      OPC_XOR:  begin wantWe = 1'b1; readA = 1'b1; readB = 1'b1; aluSel = ALU_XOR; end
      OPC_ADDI: begin wantWe = 1'b1; readA = 1'b1; useImm = 1'b1; end
      OPC_LD:   begin memRd = 1'b1; readA = 1'b1; useImm = 1'b1; end
      OPC_ST:   begin memWr = 1'b1; readA = 1'b1; readD = 1'b1; useImm = 1'b1; end
      OPC_JMP:  jmp = 1'b1;
      OPC_BEZ:  begin br = 1'b1; readA = 1'b1; end
      OPC_HALT: hlt = 1'b1;
      default:  ;
    endcase
  end

  // Load-use: the value arrives only at the end of the data step.
  always_comb begin
    hazard = eValid && loadPend && (loadRd != '0) &&
             ((readA && rs == loadRd) || (readB && rt == loadRd) ||
              (readD && rd == loadRd));
    fire   = eValid && !hazard;
  end

  always_comb begin
    ctrl.regWe  = fire && wantWe;
    ctrl.aluOp  = aluSel;
    ctrl.useImm = useImm;
    ctrl.memRd  = fire && memRd;
    ctrl.memWr  = fire && memWr;
    ctrl.jump   = fire && jmp;
    ctrl.branch = fire && br;
    ctrl.halt   = fire && hlt;
    ctrl.stall  = hazard;
  end
endmodule

// File: rtl/dslot_datapath.sv
module dslot_datapath
  import dslot_pkg::*;
#(
  parameter int PC_W    = 8,
  parameter int DADDR_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  ctrlT               ctrl,
  output logic [PC_W-1:0]    imemAddr,
  input  logic [INSTR_W-1:0] imemRdata,
  output logic [DADDR_W-1:0] dmemAddr,
  output logic               dmemRe,
  output logic               dmemWe,
  output logic [DATA_W-1:0]  dmemWdata,
  input  logic [DATA_W-1:0]  dmemRdata,
  input  logic [RA_W-1:0]    dbgAddr,
  output logic [DATA_W-1:0]  dbgData,
  output logic [OP_W-1:0]    eOp,
  output logic [RA_W-1:0]    eRd,
  output logic [RA_W-1:0]    eRs,
  output logic [RA_W-1:0]    eRt,
  output logic               eValid,
  output logic               loadPend,
  output logic [RA_W-1:0]    loadRd,
  output logic               redirect,
  output logic               done
);
  localparam int RD_PORTS = 4;
  localparam int WR_PORTS = 2;

  logic [PC_W-1:0]  pcQ, ePcQ, target;
  logic             eValidQ, haltedQ, dLoadQ;
  logic [RA_W-1:0]  dRdQ;
  logic [IMM_W-1:0] imm;
  logic [DATA_W-1:0] immData, opB, aluY;
  logic [PC_W-1:0]  immPc;
  logic [RD_PORTS-1:0][RA_W-1:0]   rfRdAddr;
  logic [RD_PORTS-1:0][DATA_W-1:0] rfRdData;
  logic [WR_PORTS-1:0]             rfWe;
  logic [WR_PORTS-1:0][RA_W-1:0]   rfWaddr;
  logic [WR_PORTS-1:0][DATA_W-1:0] rfWdata;

  // Execute-slot fields come straight from the synchronous fetch return.
  assign eOp = imemRdata[15:12];
  assign eRd = imemRdata[11:9];
  assign eRs = imemRdata[8:6];
  assign eRt = imemRdata[5:3];
  assign imm = imemRdata[IMM_W-1:0];

  assign immData = {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};
  assign immPc   = {{(PC_W-IMM_W){imm[IMM_W-1]}}, imm};

  assign rfRdAddr = {dbgAddr, eRd, eRt, eRs};
  assign rfWe     = {ctrl.regWe, dLoadQ};
  assign rfWaddr  = {eRd, dRdQ};
  assign rfWdata  = {aluY, dmemRdata};

  dslot_regfile #(
    .W(DATA_W), .NREGS(NUM_REGS), .NREAD(RD_PORTS), .NWRITE(WR_PORTS)
  ) u_rf (
    .clk(clk), .rst(rst),
    .rdAddr(rfRdAddr), .rdData(rfRdData),
    .wrEn(rfWe), .wrAddr(rfWaddr), .wrData(rfWdata)
  );

  assign opB = ctrl.useImm ? immData : rfRdData[1];

  dslot_alu #(.W(DATA_W)) u_alu (
    .opA(rfRdData[0]), .opB(opB), .op(ctrl.aluOp), .result(aluY)
  );

  assign redirect = ctrl.jump || (ctrl.branch && (rfRdData[0] == '0));
  assign target   = ePcQ + PC_W'(1) + immPc;

  // A held slot re-fetches its own word so the synchronous return repeats.
  assign imemAddr = ctrl.stall ? ePcQ : pcQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      pcQ     <= '0;
      ePcQ    <= '0;
      eValidQ <= 1'b0;
      haltedQ <= 1'b0;
      dLoadQ  <= 1'b0;
      dRdQ    <= '0;
    end else begin
      dLoadQ <= ctrl.memRd;
      dRdQ   <= eRd;
      if (!ctrl.stall) begin
        ePcQ    <= pcQ;
        eValidQ <= !(haltedQ || ctrl.halt);
        if (ctrl.halt) haltedQ <= 1'b1;
        if (!(haltedQ || ctrl.halt)) pcQ <= redirect ? target : pcQ + PC_W'(1);
      end
    end
  end

  assign dmemAddr  = aluY[DADDR_W-1:0];
  assign dmemRe    = ctrl.memRd;
  assign dmemWe    = ctrl.memWr;
  assign dmemWdata = rfRdData[2];
  assign dbgData   = rfRdData[3];
  assign eValid    = eValidQ;
  assign loadPend  = dLoadQ;
  assign loadRd    = dRdQ;
  assign done      = haltedQ;
endmodule

// File: rtl/dslot_core.sv
module dslot_core
  import dslot_pkg::*;
#(
  parameter int PC_W    = 8,
  parameter int DADDR_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  output logic [PC_W-1:0]    imemAddr,
  input  logic [INSTR_W-1:0] imemRdata,
  output logic [DADDR_W-1:0] dmemAddr,
  output logic               dmemRe,
  output logic               dmemWe,
  output logic [DATA_W-1:0]  dmemWdata,
  input  logic [DATA_W-1:0]  dmemRdata,
  input  logic [RA_W-1:0]    dbgAddr,
  output logic [DATA_W-1:0]  dbgData,
  output logic               done
);
  ctrlT            ctrlW;
  logic [OP_W-1:0] opW;
  logic [RA_W-1:0] rdW, rsW, rtW, loadRdW;
  logic            eValidW, loadPendW, redirectW;

  dslot_control u_ctl (
    .op(opW), .rd(rdW), .rs(rsW), .rt(rtW),
    .eValid(eValidW), .loadPend(loadPendW), .loadRd(loadRdW),
    .ctrl(ctrlW)
  );

  dslot_datapath #(.PC_W(PC_W), .DADDR_W(DADDR_W)) u_dp (
    .clk(clk), .rst(rst), .ctrl(ctrlW),
    .imemAddr(imemAddr), .imemRdata(imemRdata),
    .dmemAddr(dmemAddr), .dmemRe(dmemRe), .dmemWe(dmemWe),
    .dmemWdata(dmemWdata), .dmemRdata(dmemRdata),
    .dbgAddr(dbgAddr), .dbgData(dbgData),
    .eOp(opW), .eRd(rdW), .eRs(rsW), .eRt(rtW),
    .eValid(eValidW), .loadPend(loadPendW), .loadRd(loadRdW),
    .redirect(redirectW), .done(done)
  );
endmodule

// File: rtl/dslot_core_checker.sv
module dslot_core_checker #(
  parameter int PC_W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic [PC_W-1:0] imemAddr,
  input logic            dmemWe,
  input logic            done,
  input logic            stall,
  input logic            redirect
);
  // R1: reset parks fetch at 0 with nothing pending.
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (imemAddr == '0 && !done && !dmemWe));

  // R6: a load-use hold lasts a single cycle.
  p_stall_single_r6: assert property (@(posedge clk) disable iff (rst)
    stall |=> !stall);

  // R10: plain sequential flow steps the fetch address by one.
  p_fetch_step_r10: assert property (@(posedge clk) disable iff (rst)
    (!stall && !redirect && !done) |=>
      (stall || done || imemAddr == $past(imemAddr) + 1'b1));

  // R9: halt is sticky, freezes fetch and blocks stores.
  p_done_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> done);
  p_halt_freeze_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> $stable(imemAddr));
  p_halt_nowrite_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> !dmemWe);
endmodule

bind dslot_core dslot_core_checker #(.PC_W(PC_W)) u_chk (
  .clk(clk), .rst(rst), .imemAddr(imemAddr), .dmemWe(dmemWe),
  .done(done), .stall(ctrlW.stall), .redirect(redirectW)
);

// File: tb/sim_dslot_core.sv
module sim_dslot_core;
  localparam int PC_W    = 8;
  localparam int DADDR_W = 8;
  localparam int MEM_N   = 1 << PC_W;
  localparam int DMEM_N  = 1 << DADDR_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [PC_W-1:0]    imemAddr;
  logic [15:0]        imemRdata;
  logic [DADDR_W-1:0] dmemAddr;
  logic               dmemRe, dmemWe;
  logic [15:0]        dmemWdata, dmemRdata;
  logic [2:0]         dbgAddr = '0;
  logic [15:0]        dbgData;
  logic               done;
  logic               clearMem = 1'b0;

  logic [15:0] imem [MEM_N];
  logic [15:0] dmem [DMEM_N];

  int checkCount = 0;
  int failCount  = 0;
  bit finished   = 0;

  typedef struct {
    int          kind;   // 0: register, 1: data memory
    int          addr;
    logic [15:0] val;
    string       req;
  } expT;
  expT sbq[$];

  always #2 clk = ~clk;

  dslot_core #(.PC_W(PC_W), .DADDR_W(DADDR_W)) u0 (
    .clk(clk), .rst(rst), .imemAddr(imemAddr), .imemRdata(imemRdata),
    .dmemAddr(dmemAddr), .dmemRe(dmemRe), .dmemWe(dmemWe),
    .dmemWdata(dmemWdata), .dmemRdata(dmemRdata),
    .dbgAddr(dbgAddr), .dbgData(dbgData), .done(done)
  );

  always @(posedge clk) begin
    imemRdata <= imem[imemAddr];
    dmemRdata <= dmem[dmemAddr];
    if (clearMem) begin
      for (int i = 0; i < DMEM_N; i++) dmem[i] <= '0;
    end else if (dmemWe) begin
      dmem[dmemAddr] <= dmemWdata;
    end
  end

  function automatic logic [15:0] encR(int op, int rd, int rs, int rt);
    return {op[3:0], rd[2:0], rs[2:0], rt[2:0], 3'b000};
  endfunction

  function automatic logic [15:0] encI(int op, int rd, int rs, int imm);
    return {op[3:0], rd[2:0], rs[2:0], imm[5:0]};
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp, string what);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Driver side of the scoreboard.
  task automatic expectReg(int r, logic [15:0] v, string req);
    expT e;
    e.kind = 0; e.addr = r; e.val = v; e.req = req;
    sbq.push_back(e);
  endtask

  task automatic expectMem(int a, logic [15:0] v, string req);
    expT e;
    e.kind = 1; e.addr = a; e.val = v; e.req = req;
    sbq.push_back(e);
  endtask

  // Monitor side: pops expectations once the core reports done.
  task automatic drainScoreboard();
    expT e;
    while (sbq.size() > 0) begin
      e = sbq.pop_front();
      @(negedge clk);
      if (e.kind == 0) begin
        dbgAddr = e.addr[2:0];
        #1;
        check(e.req, dbgData, e.val, $sformatf("reg r%0d", e.addr));
      end else begin
        check(e.req, dmem[e.addr], e.val, $sformatf("mem[%0d]", e.addr));
      end
    end
  endtask

  task automatic clearProgram();
    for (int i = 0; i < MEM_N; i++) imem[i] = 16'h0000;
  endtask

  task automatic runProgram(string name, int expCycles, bit checkReset);
    int n;
    int frozen;
    logic [PC_W-1:0] parked;
    @(negedge clk);
    rst = 1'b1;
    clearMem = 1'b1;
    repeat (2) @(negedge clk);
    clearMem = 1'b0;
    if (checkReset) begin
      // R1: state while reset is held.
      check("R1", 16'(imemAddr), 16'h0000, {name, " fetch address in reset"});
      check("R1", 16'(done), 16'h0000, {name, " done in reset"});
      check("R1", 16'(dmemWe), 16'h0000, {name, " write strobe in reset"});
      for (int r = 0; r < 8; r++) begin
        dbgAddr = r[2:0];
        #1;
        check("R1", dbgData, 16'h0000, $sformatf("%s r%0d after reset", name, r));
      end
    end
    @(negedge clk);
    rst = 1'b0;
    n = 0;
    while (n < 2000) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (done) break;
    end
    check("R9", 16'(done), 16'h0001, {name, " reached halt"});
    if (expCycles > 0)
      check(expCycles == 11 ? "R10" : "R6", 16'(n), 16'(expCycles), {name, " cycles to done"});
    parked = imemAddr;
    frozen = 1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (imemAddr !== parked || dmemWe !== 1'b0 || done !== 1'b1) frozen = 0;
    end
    check("R9", 16'(frozen), 16'h0001, {name, " frozen after halt"});
    drainScoreboard();
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      finished = 1;
      checkCount++;
      failCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
      $finish;
    end
  end

  initial begin
    // Program A: ALU operations, back-to-back use, r0, kill after halt.
    clearProgram();
    imem[0]  = encI(6, 1, 0, 5);
    imem[1]  = encI(6, 2, 0, -3);
    imem[2]  = encR(1, 3, 1, 2);
    imem[3]  = encR(2, 4, 3, 1);
    imem[4]  = encR(3, 5, 1, 2);
    imem[5]  = encR(4, 6, 1, 2);
    imem[6]  = encR(5, 7, 6, 1);
    imem[7]  = encI(6, 0, 1, 7);
    imem[8]  = encR(1, 2, 0, 0);
    imem[9]  = encI(15, 0, 0, 0);
    imem[10] = encI(6, 1, 0, 9);
    expectReg(0, 16'h0000, "R3");
    expectReg(1, 16'h0005, "R9");
    expectReg(2, 16'h0000, "R3");
    expectReg(3, 16'h0002, "R4");
    expectReg(4, 16'hFFFD, "R2");
    expectReg(5, 16'h0005, "R2");
    expectReg(6, 16'hFFFD, "R2");
    expectReg(7, 16'hFFF8, "R2");
    runProgram("alu", 11, 1'b0);

    // Program B: loads, stores and load-use holds.
    clearProgram();
    imem[0]  = encI(6, 1, 0, 10);
    imem[1]  = encI(6, 2, 0, 7);
    imem[2]  = encI(8, 2, 1, 2);
    imem[3]  = encI(8, 1, 1, -1);
    imem[4]  = encI(7, 3, 1, 2);
    imem[5]  = encR(1, 4, 3, 3);
    imem[6]  = encI(7, 5, 1, -1);
    imem[7]  = 16'h0000;
    imem[8]  = encR(1, 6, 5, 1);
    imem[9]  = encI(7, 7, 0, 12);
    imem[10] = encI(8, 7, 0, 20);
    imem[11] = encI(7, 2, 0, 9);
    imem[12] = encI(6, 2, 2, 1);
    imem[13] = encI(15, 0, 0, 0);
    expectMem(12, 16'd7, "R5");
    expectMem(9, 16'd10, "R5");
    expectMem(20, 16'd7, "R6");
    expectReg(1, 16'd10, "R5");
    expectReg(2, 16'd11, "R6");
    expectReg(3, 16'd7, "R5");
    expectReg(4, 16'd14, "R6");
    expectReg(5, 16'd10, "R5");
    expectReg(6, 16'd20, "R5");
    expectReg(7, 16'd7, "R5");
    runProgram("mem", 18, 1'b1);

    // Program C: delayed jump and branches, taken, not taken, backward.
    clearProgram();
    imem[0]  = encI(6, 1, 0, 1);
    imem[1]  = encI(9, 0, 0, 3);
    imem[2]  = encI(6, 2, 0, 2);
    imem[3]  = encI(6, 3, 0, 3);
    imem[4]  = encI(6, 3, 0, 4);
    imem[5]  = encI(10, 0, 1, 4);
    imem[6]  = encI(6, 4, 0, 6);
    imem[7]  = encI(6, 5, 0, 7);
    imem[8]  = encI(10, 0, 0, 3);
    imem[9]  = encI(6, 6, 0, 9);
    imem[10] = encI(6, 7, 0, 1);
    imem[11] = encI(6, 7, 0, 2);
    imem[12] = encI(6, 3, 3, 5);
    imem[13] = encI(6, 4, 4, 1);
    imem[14] = encI(10, 0, 7, -2);
    imem[15] = encI(6, 7, 0, 1);
    imem[16] = encI(15, 0, 0, 0);
    expectReg(1, 16'd1, "R8");
    expectReg(2, 16'd2, "R7");
    expectReg(3, 16'd5, "R7");
    expectReg(4, 16'd8, "R8");
    expectReg(5, 16'd7, "R8");
    expectReg(6, 16'd9, "R8");
    expectReg(7, 16'd1, "R8");
    runProgram("branch", 17, 1'b1);

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
      $finish;
    end
  end
endmodule